// File: doc/BRIEF.md
# Write Burst Assembly Buffer

This block sits between the downstream link receiver and the DRAM write path. Write data reaches it as 72-bit slices, one per link frame. Every four slices in a row make one complete entry, and the buffer keeps up to four such entries. A write command carries no pointer to any data. Each accepted command claims the oldest complete entry that no earlier command has claimed yet. That entry then leaves the block as four 72-bit beats on back-to-back cycles, with a valid strobe and a last-beat marker.

The entries live in a single memory of DEPTH×4 words of 72 bits, addressed by {entry slot, slice index}, so the memory can map to block RAM. Slices are written straight into their final slot, and beats are read from the same slot when its burst is due. A command that arrives while a burst is still streaming is queued and gets its own burst right after the current one. Two sticky flags report a slice dropped because the buffer was full and a command that found no entry to claim.

Top module: `wr_burst_buffer`

## Requirements
- R1: After a synchronous reset, overflow, underflow and beat_valid are 0. No entry is stored, and the slice position is back to the first slice of a new entry.
- R2: An entry counts as available only once its fourth slice is accepted. A write command that arrives while only a partial entry exists sets underflow and produces no beats.
- R3: When a write command is accepted in cycle c, beat_valid is 0 in cycle c+1 and 1 in cycles c+2 to c+5. beat_data carries the entry's slices in the order they arrived. beat_last is 1 only together with the fourth beat.
- R4: Entries are consumed in the order they were completed. The oldest unclaimed complete entry always goes first.
- R5: The buffer holds at most four complete entries. A slice that arrives while four complete entries are stored is dropped and sets overflow, which stays 1 until reset. The dropped slice does not advance the slice position. This holds even in a cycle where a burst finishes and frees a slot.
- R6: A write command that arrives when every stored complete entry is already claimed by earlier commands sets underflow, which stays 1 until reset. It produces no beats and does not disturb bursts already claimed.
- R7: Commands accepted while a burst is streaming are queued. Each one produces its own four-beat burst, starting in the cycle right after the previous burst's last beat, with no gap.
- R8: A write command in the same cycle as the fourth slice of the only entry being built sees no complete entry. It sets underflow, and that entry stays available for a later command.
- R9: The slot of a burst becomes free after its last beat is read. New slices can then complete a fresh entry, even after an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slice_valid | input | 1 | A write-data slice is present this cycle |
| slice_data | input | 72 | Write-data slice |
| wr_cmd | input | 1 | Untagged write command, one per cycle at most |
| beat_valid | output | 1 | beat_data holds a burst beat |
| beat_data | output | 72 | Burst beat toward the DRAM interface |
| beat_last | output | 1 | Marks the fourth beat of a burst |
| overflow | output | 1 | Sticky: a slice was dropped because the buffer was full |
| underflow | output | 1 | Sticky: a command found no available entry |

## Verification
Slice acceptance and command acceptance can fall in the same cycle. Two collisions matter most: the fourth slice of an entry arriving together with the command that wants it, and a slice reaching a full buffer in the cycle a burst frees a slot. The bench creates these by driving slice_valid and wr_cmd together at chosen fill levels. It also runs a long stretch of random interleaving. An occupancy model in the bench predicts, from the requirements, whether each slice and each command is accepted. Every beat and both flags are compared with that prediction each cycle.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int unsigned SLICE_W_DEF = 72;
  localparam int unsigned BEATS_DEF   = 4;
  localparam int unsigned DEPTH_DEF   = 4;
endpackage

// File: rtl/wbuf_assembler.sv
module wbuf_assembler #(
  parameter int unsigned SLICE_W = 72,
  parameter int unsigned BEATS   = 4,
  parameter int unsigned DEPTH   = 4,
  localparam int unsigned BEAT_W = $clog2(BEATS),
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = PTR_W + BEAT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slice_valid,
  input  logic [SLICE_W-1:0] slice_data,
  input  logic               full,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [SLICE_W-1:0] wr_data,
  output logic               commit,
  output logic               overflow
);
  logic [BEAT_W-1:0] sidx_q;
  logic [PTR_W-1:0]  wptr_q;
  logic              ovf_q;

  always_comb begin
    wr_en   = slice_valid && !full;
    wr_addr = {wptr_q, sidx_q};
    wr_data = slice_data;
    commit  = wr_en && (sidx_q == BEAT_W'(BEATS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sidx_q <= '0;
      wptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        sidx_q <= sidx_q + BEAT_W'(1);
        if (commit) wptr_q <= wptr_q + PTR_W'(1);
      end
      if (slice_valid && full) ovf_q <= 1'b1;
    end
  end

  assign overflow = ovf_q;

  // R5: the overflow flag never clears without reset
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R5: a dropped slice leaves the slice position and slot untouched
  a_r5_drop_holds_position: assert property (@(posedge clk) disable iff (rst)
    (slice_valid && full) |=> ($stable(sidx_q) && $stable(wptr_q)));
endmodule

// File: rtl/wbuf_ram.sv
module wbuf_ram #(
  parameter int unsigned WIDTH  = 72,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/wbuf_reader.sv
module wbuf_reader #(
  parameter int unsigned SLICE_W = 72,
  parameter int unsigned BEATS   = 4,
  parameter int unsigned DEPTH   = 4,
  localparam int unsigned BEAT_W = $clog2(BEATS),
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = PTR_W + BEAT_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_cmd,
  input  logic [CNT_W-1:0]   count,
  input  logic [SLICE_W-1:0] rd_data,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               done,
  output logic               beat_valid,
  output logic [SLICE_W-1:0] beat_data,
  output logic               beat_last,
  output logic               underflow
);
  logic [CNT_W-1:0]  pend_q;
  logic [BEAT_W-1:0] bidx_q;
  logic [PTR_W-1:0]  rptr_q;
  logic              active;
  logic              accept;
  logic              valid_q;
  logic              last_q;
  logic              unf_q;

  always_comb begin
    active  = (pend_q != '0);
    accept  = wr_cmd && (count != pend_q);
    rd_en   = active;
    rd_addr = {rptr_q, bidx_q};
    done    = active && (bidx_q == BEAT_W'(BEATS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      bidx_q  <= '0;
      rptr_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      pend_q  <= pend_q + CNT_W'(accept) - CNT_W'(done);
      valid_q <= active;
      last_q  <= done;
      if (active) begin
        bidx_q <= bidx_q + BEAT_W'(1);
        if (done) rptr_q <= rptr_q + PTR_W'(1);
      end
      if (wr_cmd && !accept) unf_q <= 1'b1;
    end
  end

  assign beat_valid = valid_q;
  assign beat_last  = last_q;
  assign beat_data  = rd_data;
  assign underflow  = unf_q;

  // R6: the underflow flag never clears without reset
  a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);
  // R6: claimed bursts never exceed stored complete entries
  a_r6_claims_within_store: assert property (@(posedge clk) disable iff (rst)
    pend_q <= count);
  // R7: a burst streams without gaps until its last beat
  a_r7_burst_contiguous: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_last) |=> beat_valid);
  // R3: the last marker only accompanies a valid beat
  a_r3_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid);
endmodule

// File: rtl/wr_burst_buffer.sv
module wr_burst_buffer
  import wbuf_pkg::*;
#(
  parameter int unsigned SLICE_W = SLICE_W_DEF,
  parameter int unsigned BEATS   = BEATS_DEF,
  parameter int unsigned DEPTH   = DEPTH_DEF,
  localparam int unsigned BEAT_W = $clog2(BEATS),
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = PTR_W + BEAT_W,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slice_valid,
  input  logic [SLICE_W-1:0] slice_data,
  input  logic               wr_cmd,
  output logic               beat_valid,
  output logic [SLICE_W-1:0] beat_data,
  output logic               beat_last,
  output logic               overflow,
  output logic               underflow
);
  logic [CNT_W-1:0]   count_q;
  logic               full;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr;
  logic [SLICE_W-1:0] wr_data;
  logic               commit;
  logic               rd_en;
  logic [ADDR_W-1:0]  rd_addr;
  logic [SLICE_W-1:0] rd_data;
  logic               done;

  assign full = (count_q == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_q + CNT_W'(commit) - CNT_W'(done);
  end

  wbuf_assembler #(.SLICE_W(SLICE_W), .BEATS(BEATS), .DEPTH(DEPTH)) u_asm (
    .clk(clk), .rst(rst), .slice_valid(slice_valid), .slice_data(slice_data),
    .full(full), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .overflow(overflow)
  );

  wbuf_ram #(.WIDTH(SLICE_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  wbuf_reader #(.SLICE_W(SLICE_W), .BEATS(BEATS), .DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .count(count_q), .rd_data(rd_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .done(done), .beat_valid(beat_valid),
    .beat_data(beat_data), .beat_last(beat_last), .underflow(underflow)
  );

  // R5: stored complete entries never exceed the capacity
  a_r5_capacity_bound: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));
  // R2: an entry completes only into a slot that is free
  a_r2_commit_has_room: assert property (@(posedge clk) disable iff (rst)
    commit |-> (count_q < CNT_W'(DEPTH)));
  // R9: a finished burst releases exactly one slot
  a_r9_done_frees_slot: assert property (@(posedge clk) disable iff (rst)
    (done && !commit) |=> (count_q == $past(count_q) - CNT_W'(1)));
endmodule

// File: tb/wr_burst_buffer_bench.sv
`timescale 1ns/1ps
module wr_burst_buffer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slice_valid = 1'b0;
  logic [71:0] slice_data = '0;
  logic        wr_cmd = 1'b0;
  logic        beat_valid;
  logic [71:0] beat_data;
  logic        beat_last;
  logic        overflow;
  logic        underflow;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  bit finished = 1'b0;

  // bench model state
  int m_cnt, m_pend, m_sidx, m_beat, mon_idx;
  bit m_ovf, m_unf;
  logic [71:0] part [4];
  logic [71:0] ent_q[$];
  logic [71:0] exp_q[$];
  int seq = 0;

  always #2.5 clk = ~clk;

  wr_burst_buffer u_wr_burst_buffer (
    .clk(clk), .rst(rst), .slice_valid(slice_valid), .slice_data(slice_data),
    .wr_cmd(wr_cmd), .beat_valid(beat_valid), .beat_data(beat_data),
    .beat_last(beat_last), .overflow(overflow), .underflow(underflow)
  );

  function automatic logic [71:0] pat(int n);
    return {8'hC3, 32'(n * 32'h9E37_79B1), 32'(~n)};
  endfunction

  task automatic chk(bit ok, string req, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // beat monitor (R3, R4, R7)
  always @(negedge clk) begin
    if (!rst && beat_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected beat", beat_data, '0);
      end else begin
        chk(beat_data == exp_q[0], "R4 beat data/order", beat_data, exp_q[0]);
        chk(beat_last == (mon_idx == 3), "R3 beat_last", 72'(beat_last), 72'(mon_idx == 3));
        void'(exp_q.pop_front());
        mon_idx = (mon_idx + 1) % 4;
      end
    end
  end

  always @(posedge clk) begin
    cycle++;
    if (cycle > 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycle, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset();
    slice_valid = 1'b0; wr_cmd = 1'b0; rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_pend = 0; m_sidx = 0; m_beat = 0; mon_idx = 0;
    m_ovf = 1'b0; m_unf = 1'b0;
    ent_q.delete(); exp_q.delete();
  endtask

  task automatic step(bit sv, logic [71:0] sd, bit cmd);
    int oc, op;
    bit commit, done;
    slice_valid = sv; slice_data = sd; wr_cmd = cmd;
    @(posedge clk);
    oc = m_cnt; op = m_pend; commit = 1'b0; done = 1'b0;
    if (sv) begin
      if (oc == 4) m_ovf = 1'b1;
      else begin
        part[m_sidx] = sd;
        if (m_sidx == 3) begin commit = 1'b1; m_sidx = 0; end
        else m_sidx++;
      end
    end
    if (cmd) begin
      if (oc == op) m_unf = 1'b1;
      else begin
        for (int j = 0; j < 4; j++) exp_q.push_back(ent_q[op*4 + j]);
        m_pend++;
      end
    end
    if (op != 0) begin
      if (m_beat == 3) begin done = 1'b1; m_beat = 0; end
      else m_beat++;
    end
    if (done) begin
      for (int j = 0; j < 4; j++) void'(ent_q.pop_front());
      m_pend--;
    end
    if (commit) for (int j = 0; j < 4; j++) ent_q.push_back(part[j]);
    m_cnt = oc + int'(commit) - int'(done);
    @(negedge clk);
    slice_valid = 1'b0; wr_cmd = 1'b0;
    chk(overflow == m_ovf, "R5 overflow flag", 72'(overflow), 72'(m_ovf));
    chk(underflow == m_unf, "R6 underflow flag", 72'(underflow), 72'(m_unf));
  endtask

  task automatic put_slice();
    step(1'b1, pat(seq), 1'b0);
    seq++;
  endtask

  task automatic fill(int n_entries);
    for (int i = 0; i < n_entries * 4; i++) put_slice();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0);
  endtask

  initial begin
    // R1: reset state
    do_reset();
    chk(overflow == 1'b0, "R1 overflow after reset", 72'(overflow), 72'(0));
    chk(underflow == 1'b0, "R1 underflow after reset", 72'(underflow), 72'(0));
    chk(beat_valid == 1'b0, "R1 beat_valid after reset", 72'(beat_valid), 72'(0));
    step(1'b0, '0, 1'b1);
    chk(underflow == 1'b1, "R1 empty after reset", 72'(underflow), 72'(1));
    idle(6);

    // R3: burst timing after a single command
    do_reset();
    fill(1);
    step(1'b0, '0, 1'b1);
    chk(beat_valid == 1'b0, "R3 no beat in c+1", 72'(beat_valid), 72'(0));
    step(1'b0, '0, 1'b0);
    chk(beat_valid == 1'b1, "R3 first beat in c+2", 72'(beat_valid), 72'(1));
    idle(6);
    chk(exp_q.size() == 0, "R3 burst fully delivered", 72'(exp_q.size()), 72'(0));

    // R2: partial entry is not available
    do_reset();
    for (int i = 0; i < 3; i++) put_slice();
    step(1'b0, '0, 1'b1);
    chk(underflow == 1'b1, "R2 partial entry not available", 72'(underflow), 72'(1));
    idle(6);
    put_slice();
    step(1'b0, '0, 1'b1);
    idle(8);

    // R6/R7/R4: for each fill level, issue one more command than stored
    for (int lvl = 0; lvl <= 4; lvl++) begin
      do_reset();
      fill(lvl);
      for (int k = 0; k <= lvl; k++) step(1'b0, '0, 1'b1);
      chk(underflow == 1'b1, "R6 excess command", 72'(underflow), 72'(1));
      idle(4 * lvl + 4);
      chk(exp_q.size() == 0, "R7 queued bursts drained", 72'(exp_q.size()), 72'(0));
    end

    // R5: overflow at capacity, then R9 freed slot reused
    do_reset();
    fill(4);
    put_slice();
    chk(overflow == 1'b1, "R5 slice dropped at full", 72'(overflow), 72'(1));
    step(1'b0, '0, 1'b1);
    step(1'b1, pat(seq), 1'b0); seq++;
    step(1'b1, pat(seq), 1'b0); seq++;
    step(1'b1, pat(seq), 1'b0); seq++;
    step(1'b1, pat(seq), 1'b0); seq++; // same cycle as burst end: dropped
    idle(2);
    fill(1);
    for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1);
    idle(20);
    chk(exp_q.size() == 0, "R9 reused slot drained", 72'(exp_q.size()), 72'(0));

    // R8: command together with the fourth slice
    do_reset();
    for (int i = 0; i < 3; i++) put_slice();
    step(1'b1, pat(seq), 1'b1); seq++;
    chk(underflow == 1'b1, "R8 same-cycle command underflows", 72'(underflow), 72'(1));
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    chk(beat_valid == 1'b1, "R8 entry still available", 72'(beat_valid), 72'(1));
    idle(6);

    // random interleaving against the model
    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int i = 0; i < 800; i++) begin
        bit sv, cm;
        sv = (($urandom % 4) != 0);
        cm = (($urandom % (3 + r)) == 0);
        step(sv, pat(seq), cm);
        seq++;
      end
      idle(24);
      chk(exp_q.size() == 0, "R7 random run drained", 72'(exp_q.size()), 72'(0));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule